// File: doc/BRIEF.md
# SPI Bit Clock Generator

This block derives the serial clock of an SPI master from the system clock through two dividers in series. The first is an even prescaler. The second divides its output by one more than an 8-bit rate value. One full serial bit lasts `P * (R + 1)` system clocks. `P` is the even prescale, from 2 to 254, and `R` is the rate value, from 0 to 255. The fastest setting gives a serial clock at half the system clock. The slowest gives the system clock divided by 65024.

Software chooses the two divisor values and presents them on the configuration inputs. When the block is enabled it toggles the serial clock at every half bit period. It also emits a one-cycle pulse for each transition:

- The leading pulse marks the move away from the idle level.
- The trailing pulse marks the return to the idle level.

From these two pulses and the clock-phase input, the block produces the sample strobe and the shift strobe that the shift register uses. When the block is disabled, its counters are cleared and the serial clock rests at the selected idle polarity.

Top module: `spi_bitclk_gen`

## Requirements
- R1: With even prescale `P` and rate value `R`, each half bit period lasts `(P/2)*(R+1)` system clocks, with `H = (P/2)*(R+1)`. The first leading transition appears after the H-th rising clock edge at which `en_i` is high. Each later transition follows H edges after the one before it.
- R2: Bit 0 of `prescale_i` is ignored, so an odd value acts as the next lower even value. A prescale of 0 or 1 acts as 2.
- R3: The rate value covers its whole range 0 to 255. The fastest setting (prescale 2, rate 0) gives a half period of 1 cycle. The slowest setting (prescale 254, rate 255) gives a half period of 32512 cycles.
- R4: A change to `prescale_i` or `rate_i` while enabled has no effect on the current bit. It is captured at the next trailing transition and sets the length of every following half period.
- R5: While `en_i` is low, `sclk_o` equals `cpol_i` one cycle later and no pulse output is high. On re-enable the counters start again from zero, so the first leading transition again needs H enabled edges.
- R6: `lead_o` is a one-cycle pulse in the cycle in which `sclk_o` has just left the idle level (`sclk_o != cpol_i`). `trail_o` is a one-cycle pulse in the cycle in which `sclk_o` has just returned to it (`sclk_o == cpol_i`).
- R7: When `cpha_i` is 0, `sample_o` follows `lead_o` and `shift_o` follows `trail_o`. When `cpha_i` is 1 the two are swapped.
- R8: During reset `sclk_o` is 0 and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the generator; low holds it idle and cleared |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Clock phase: 0 samples on leading transitions, 1 on trailing |
| prescale_i | input | PRE_W | Even prescale value; bit 0 ignored, 0 acts as 2 |
| rate_i | input | RATE_W | Rate value R; divides by R+1 |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | Pulse when the serial clock leaves its idle level |
| trail_o | output | 1 | Pulse when the serial clock returns to its idle level |
| sample_o | output | 1 | Sample strobe for the shifter |
| shift_o | output | 1 | Shift strobe for the shifter |

## Verification
The divider is run with a table of settings that separates the two stages:

- The smallest product tests the one-cycle half period.
- Odd and zero prescale values show that the low bit is dropped and that zero is treated as 2.
- Settings with a large rate value on a small prescale, and the reverse, show that the product is formed and not a sum.
- The extreme corner proves the 32512-cycle half period.

Each setting is run under a different polarity and phase, so the idle level and the routing of the sample and shift strobes are checked with it. Directed cases cover three more situations: a divisor change in the middle of a bit, which must change only the following bits; a disable before the first transition, which must restart the count; and the reset state.

// File: rtl/spi_bitclk_pkg.sv
package spi_bitclk_pkg;
  typedef enum logic {
    HALF_LEAD  = 1'b0,
    HALF_TRAIL = 1'b1
  } half_e;

  localparam int unsigned DEF_PRE_W  = 8;
  localparam int unsigned DEF_RATE_W = 8;
endpackage

// File: rtl/spi_bitclk_cfg.sv
module spi_bitclk_cfg #(
  parameter int unsigned PRE_W  = spi_bitclk_pkg::DEF_PRE_W,
  parameter int unsigned RATE_W = spi_bitclk_pkg::DEF_RATE_W,
  localparam int unsigned HW    = PRE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [HW-1:0]     pre_max_o,
  output logic [RATE_W-1:0] rate_max_o
);
  logic [HW-1:0] half_pre;
  logic [HW-1:0] pre_max_d;

  // Drop bit 0; a half-prescale of 0 behaves as 1
  always_comb begin
    half_pre  = prescale_i[PRE_W-1:1];
    pre_max_d = (half_pre == '0) ? '0 : half_pre - HW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_max_o  <= '0;
      rate_max_o <= '0;
    end else if (load_i) begin
      pre_max_o  <= pre_max_d;
      rate_max_o <= rate_i;
    end
  end
endmodule

// File: rtl/spi_bitclk_cnt.sv
module spi_bitclk_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] max_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = run_i && step_i && (cnt_q == max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/spi_bitclk_gen.sv
module spi_bitclk_gen #(
  parameter int unsigned PRE_W  = spi_bitclk_pkg::DEF_PRE_W,
  parameter int unsigned RATE_W = spi_bitclk_pkg::DEF_RATE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o,
  output logic              sample_o,
  output logic              shift_o
);
  import spi_bitclk_pkg::*;

  localparam int unsigned HW = PRE_W - 1;

  logic [HW-1:0]     pre_max;
  logic [RATE_W-1:0] rate_max;
  logic              pre_wrap;
  logic              half_tick;
  logic              cfg_load;
  half_e             half_q;
  logic              sclk_q, lead_q, trail_q;

  // Divisors latch while idle or at the end of a bit
  assign cfg_load = !en_i || (half_tick && half_q == HALF_TRAIL);

  spi_bitclk_cfg #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_load),
    .prescale_i (prescale_i),
    .rate_i     (rate_i),
    .pre_max_o  (pre_max),
    .rate_max_o (rate_max)
  );

  spi_bitclk_cnt #(.W(HW)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .step_i (1'b1),
    .max_i  (pre_max),
    .wrap_o (pre_wrap)
  );

  spi_bitclk_cnt #(.W(RATE_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .step_i (pre_wrap),
    .max_i  (rate_max),
    .wrap_o (half_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= HALF_LEAD;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!en_i) begin
      half_q  <= HALF_LEAD;
      sclk_q  <= cpol_i;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= half_tick && (half_q == HALF_LEAD);
      trail_q <= half_tick && (half_q == HALF_TRAIL);
      if (half_tick) begin
        sclk_q <= ~sclk_q;
        half_q <= (half_q == HALF_LEAD) ? HALF_TRAIL : HALF_LEAD;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign lead_o   = lead_q;
  assign trail_o  = trail_q;
  assign sample_o = cpha_i ? trail_q : lead_q;
  assign shift_o  = cpha_i ? lead_q  : trail_q;
endmodule

// File: rtl/spi_bitclk_gen_chk.sv
module spi_bitclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cpol_i,
  input logic cpha_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o,
  input logic sample_o,
  input logic shift_o
);
  // R5
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_i)) && !lead_o && !trail_o);

  // R6
  lead_away_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o && $stable(cpol_i)) |-> (sclk_o != cpol_i));

  // R6
  trail_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trail_o && $stable(cpol_i)) |-> (sclk_o == cpol_i));

  // R6
  lead_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |=> !lead_o);

  // R1
  toggle_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && en_i && (sclk_o != $past(sclk_o))) |-> (lead_o || trail_o));

  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, shift_o}));

  // R7
  strobe_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (cpha_i ? trail_o : lead_o));
endmodule

bind spi_bitclk_gen spi_bitclk_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .cpol_i   (cpol_i),
  .cpha_i   (cpha_i),
  .sclk_o   (sclk_o),
  .lead_o   (lead_o),
  .trail_o  (trail_o),
  .sample_o (sample_o),
  .shift_o  (shift_o)
);

// File: tb/spi_bitclk_gen_bench.sv
`timescale 1ns/1ps
module spi_bitclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [7:0] pre = 8'd2, rate = 8'd0;
  logic       sclk, lead, trail, sample, shift;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_bitclk_gen u_spi_bitclk_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cpha_i(cpha),
    .prescale_i(pre), .rate_i(rate), .sclk_o(sclk), .lead_o(lead),
    .trail_o(trail), .sample_o(sample), .shift_o(shift)
  );

  localparam int NV = 7;
  localparam int V_PRE  [NV] = '{2, 4, 3, 0, 10, 6, 254};
  localparam int V_RATE [NV] = '{0, 0, 1, 2, 4, 255, 255};
  localparam int V_HALF [NV] = '{1, 2, 2, 3, 25, 768, 32512};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts enabled edges until the chosen pulse is seen (sampled at negedge)
  task automatic wait_pulse(input bit want_trail, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
    end while (!(want_trail ? trail : lead) && n < 70000);
  endtask

  task automatic idle_cfg(input int p, input int r, input bit pol, input bit pha);
    en = 1'b0; pre = 8'(p); rate = 8'(r); cpol = pol; cpha = pha;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R8 reset state
    repeat (3) @(negedge clk);
    check("R8 sclk", sclk, 0);
    check("R8 pulses", {lead, trail, sample, shift}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bit pol = i[0];
      bit pha = i[1];
      idle_cfg(V_PRE[i], V_RATE[i], pol, pha);
      // R5 idle level
      check("R5 idle sclk", sclk, pol);
      en = 1'b1;
      wait_pulse(1'b0, n);
      // R1 R2 R3 first half period
      check($sformatf("R1 lead delay vec%0d", i), n, V_HALF[i]);
      check("R6 sclk after lead", sclk, !pol);
      // R7 sample/shift routing on the leading pulse
      check("R7 sample on lead", sample, !pha);
      check("R7 shift on lead", shift, pha);
      wait_pulse(1'b1, n);
      check($sformatf("R1 trail delay vec%0d", i), n, V_HALF[i]);
      check("R6 sclk after trail", sclk, pol);
      check("R7 sample on trail", sample, pha);
      if (V_HALF[i] < 100) begin
        wait_pulse(1'b0, n);
        check($sformatf("R1 next lead vec%0d", i), n, V_HALF[i]);
      end
    end

    // R5 disable before the first edge restarts the count
    idle_cfg(10, 1, 1'b0, 1'b0);      // H = 10
    en = 1'b1;
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R5 no pulse while idle", {lead, trail}, 0);
    check("R5 sclk idle", sclk, 0);
    en = 1'b1;
    wait_pulse(1'b0, n);
    check("R5 restart from zero", n, 10);

    // R4 mid-bit divisor change applies from the next bit
    idle_cfg(4, 0, 1'b0, 1'b0);       // H = 2
    en = 1'b1;
    wait_pulse(1'b0, n);
    check("R4 old lead", n, 2);
    pre = 8'd8; rate = 8'd1;          // new H = 8
    wait_pulse(1'b1, n);
    check("R4 old trail", n, 2);
    wait_pulse(1'b0, n);
    check("R4 new lead", n, 8);
    wait_pulse(1'b1, n);
    check("R4 new trail", n, 8);

    // R2 odd prescale 1 acts as 2
    idle_cfg(1, 0, 1'b1, 1'b0);
    en = 1'b1;
    wait_pulse(1'b0, n);
    check("R2 prescale 1", n, 1);
    wait_pulse(1'b1, n);
    check("R3 fastest trail", n, 1);
    en = 1'b0;
    @(negedge clk);
    check("R5 sclk returns idle", sclk, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule